// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block runs machine instructions out of a read-only microprogram store. When a machine opcode is offered, the opcode sets the starting address of that instruction's micro-routine. The sequencer then steps through that routine one control word per cycle. Each control word holds one enable bit for every elementary datapath micro-operation. Any number of those bits may be high in the same step, and the block passes them to the datapath unchanged.

Two registers hide the latency of the store. One holds the word that is executing now. The other holds the address of the word being fetched for the next cycle. Straight-line code therefore issues one word per cycle with no gaps. A word can request a conditional transfer. It selects one of sixteen condition inputs, and if that input is high the prefetched word is thrown away, the target address is fetched, and one empty cycle with all micro-operation enables low appears. A marker bit in the last word of a routine ends the machine instruction, and the sequencer goes back to waiting for an opcode.

The store sits outside the block. The block drives an address and reads the word at that address back in the same cycle.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is low at a clock edge (synchronous, active low), the block clears itself. Afterwards `opc_ready`=1, `uop_valid`=0, `uop`=0, `instr_done`=0 and `rom_addr`=0 until an opcode is accepted.
- R2: When `opc_valid` and `opc_ready` are both high at an edge, the opcode is accepted and its start address is opcode × 2^(ADDR_W−OPC_W). In the next cycle `rom_addr` equals that start address and `uop_valid`=0 (one fill cycle). The cycle after that, the word at the start address is issued.
- R3: Word layout, from bit 0 upward: bits [N_UOPS−1:0] are micro-operation enables, bit N_UOPS is the end marker, bit N_UOPS+1 requests a conditional transfer, the next 4 bits select the condition input, and the top ADDR_W bits are the transfer target. While a word is issued, `uop` equals its enable field with every set bit passed through, and `uop_valid`=1.
- R4: During each issue cycle, `rom_addr` already points at the following address, so the next word is being prefetched. The address wraps from the top of the store to 0.
- R5: `instr_done` is high exactly in the cycle in which a word with the end marker is issued. In the next cycle `opc_ready`=1 and `uop_valid`=0, and the prefetched word is discarded.
- R6: If an issued word has the transfer bit set and the selected condition input is high, the next cycle is a bubble with `uop_valid`=0, `uop`=0 and `rom_addr` equal to the target field. The word at the target is issued in the cycle after that.
- R7: If the transfer bit is set but the selected condition input is low, the next consecutive word is issued in the very next cycle, with no bubble.
- R8: If a word has both the end marker and the transfer bit set, the end marker wins. The instruction ends as in R5 and no transfer or bubble takes place.
- R9: `opc_valid` and `opc` are ignored while `opc_ready` is low. A new opcode offered during execution does not change the sequence of words issued.
- R10: Reset applied in the middle of a routine abandons it and restores the state given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opc_valid | input | 1 | A machine opcode is offered |
| opc | input | OPC_W | Machine opcode |
| cond | input | 16 | Condition inputs tested by transfer words |
| rom_data | input | WORD_W | Control word read from the store at `rom_addr` |
| rom_addr | output | ADDR_W | Address being fetched (next word to issue) |
| opc_ready | output | 1 | Sequencer is idle and will accept an opcode |
| uop | output | N_UOPS | Micro-operation enables of the issued word |
| uop_valid | output | 1 | A word is being issued this cycle |
| instr_done | output | 1 | The issued word ends the machine instruction |

## Verification
The bench goes after the cycle right after a taken transfer. A design that forgot to flush would issue the stale prefetched word there, and one that skipped the bubble would show the target word a cycle early. It checks words that carry both the end marker and a transfer request, where a wrong priority would produce a bubble and carry on instead of returning to idle. It also runs a routine that crosses the top of the store, where a missing wrap would read past the last address. Finally, it offers a different opcode during execution and applies reset in the middle of a routine, which catches a sequencer that reloads its address while busy or keeps a stale word after reset.

// File: rtl/useq_pkg.sv
// Shared definitions for the microprogram sequencer.
// Assumes: the condition-select field is always 4 bits wide (16 inputs).
package useq_pkg;
    localparam int COND_SEL_W = 4;
    localparam int COND_N     = 1 << COND_SEL_W;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,   // waiting for an opcode
        SQ_FILL = 2'd1,   // fetching first word of a routine or a transfer target
        SQ_EXEC = 2'd2    // issuing the buffered word, prefetching the next
    } sq_state_e;
endpackage

// File: rtl/useq_branch_unit.sv
// Splits the executing control word into its fields and decides whether
// a conditional transfer is taken. Purely combinational.
// Assumes: the field layout documented in the brief (enables at the bottom).
module useq_branch_unit
    import useq_pkg::*;
#(
    parameter int N_UOPS = 8,
    parameter int ADDR_W = 6,
    parameter int WORD_W = N_UOPS + 2 + COND_SEL_W + ADDR_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic [COND_N-1:0] cond,
    output logic [N_UOPS-1:0] uops,
    output logic              is_end,
    output logic              taken,
    output logic [ADDR_W-1:0] target
);
    localparam int END_BIT = N_UOPS;
    localparam int CBR_BIT = N_UOPS + 1;
    localparam int SEL_LO  = N_UOPS + 2;
    localparam int TGT_LO  = SEL_LO + COND_SEL_W;

    logic [COND_SEL_W-1:0] sel;

    // Field extraction and condition test.
    always_comb begin
        uops   = word[N_UOPS-1:0];
        is_end = word[END_BIT];
        sel    = word[SEL_LO +: COND_SEL_W];
        target = word[TGT_LO +: ADDR_W];
        taken  = word[CBR_BIT] & cond[sel];
    end
endmodule

// File: rtl/useq_addr_reg.sv
// Micro-address register: holds the address being fetched from the store.
// Loads an opcode start address, a transfer target, or steps by one.
// Assumes: at most one load request per cycle; start load has priority.
module useq_addr_reg #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              load_tgt,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] pc
);
    // Address update with synchronous reset; stepping wraps modulo 2^ADDR_W.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc <= '0;
        else if (load_start) pc <= start_addr;
        else if (load_tgt)   pc <= tgt_addr;
        else if (step)       pc <= pc + 1'b1;
    end
endmodule

// File: rtl/useq_prefetch_buf.sv
// Holds the control word that is executing. It is loaded from the store
// output and cleared when its contents must not be issued.
// Assumes: clear has priority over load.
module useq_prefetch_buf #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    // Word capture; reset and clear empty the buffer to all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n)     dout <= '0;
        else if (clear) dout <= '0;
        else if (load)  dout <= din;
    end
endmodule

// File: rtl/useq_ctrl.sv
// Sequencer state machine: idle / fill / execute. Turns the decoded end
// marker and transfer decision into load, step and flush strobes.
// Assumes: is_end and taken are meaningful only in the execute state.
module useq_ctrl
    import useq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      opc_valid,
    input  logic      is_end,
    input  logic      taken,
    output sq_state_e state,
    output logic      load_start,
    output logic      load_tgt,
    output logic      step,
    output logic      buf_load,
    output logic      buf_clear
);
    sq_state_e nxt;

    // Next-state and strobe decode; the end marker outranks a transfer.
    always_comb begin
        nxt        = state;
        load_start = 1'b0;
        load_tgt   = 1'b0;
        step       = 1'b0;
        buf_load   = 1'b0;
        buf_clear  = 1'b0;
        unique case (state)
            SQ_IDLE: begin
                load_start = opc_valid;
                if (opc_valid) nxt = SQ_FILL;
            end
            SQ_FILL: begin
                buf_load = 1'b1;
                step     = 1'b1;
                nxt      = SQ_EXEC;
            end
            SQ_EXEC: begin
                if (is_end) begin
                    buf_clear = 1'b1;
                    nxt       = SQ_IDLE;
                end else if (taken) begin
                    load_tgt  = 1'b1;
                    buf_clear = 1'b1;
                    nxt       = SQ_FILL;
                end else begin
                    buf_load = 1'b1;
                    step     = 1'b1;
                end
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    AST_FILL_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        state == SQ_FILL |=> state == SQ_EXEC);                       // R2
    AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_EXEC && is_end) |=> state == SQ_IDLE);           // R8
endmodule

// File: rtl/useq_sequencer.sv
// Top of the microprogram sequencer. It fetches control words from an
// external combinational store, issues one per cycle and prefetches the
// next one. It also handles conditional transfers with a one-cycle bubble
// and ends a machine instruction on the end marker.
// Assumes: rom_data is valid in the same cycle as rom_addr; ADDR_W >= OPC_W.
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int N_UOPS = 8,
    parameter int ADDR_W = 6,
    parameter int OPC_W  = 4,
    parameter int WORD_W = N_UOPS + 2 + COND_SEL_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opc_valid,
    input  logic [OPC_W-1:0]  opc,
    input  logic [COND_N-1:0] cond,
    input  logic [WORD_W-1:0] rom_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              opc_ready,
    output logic [N_UOPS-1:0] uop,
    output logic              uop_valid,
    output logic              instr_done
);
    localparam int START_SH = ADDR_W - OPC_W;

    sq_state_e         state;
    logic              load_start, load_tgt, step, buf_load, buf_clear;
    logic [WORD_W-1:0] cur_word;
    logic [N_UOPS-1:0] cur_uops;
    logic              cur_end, cur_taken;
    logic [ADDR_W-1:0] cur_target;
    logic [ADDR_W-1:0] start_addr;

    // Opcode decode: each routine begins on a 2^START_SH boundary.
    always_comb start_addr = ADDR_W'(opc) << START_SH;

    useq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .opc_valid  (opc_valid),
        .is_end     (cur_end),
        .taken      (cur_taken),
        .state      (state),
        .load_start (load_start),
        .load_tgt   (load_tgt),
        .step       (step),
        .buf_load   (buf_load),
        .buf_clear  (buf_clear)
    );

    useq_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (load_start),
        .start_addr (start_addr),
        .load_tgt   (load_tgt),
        .tgt_addr   (cur_target),
        .step       (step),
        .pc         (rom_addr)
    );

    useq_prefetch_buf #(.WORD_W(WORD_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (buf_load),
        .clear (buf_clear),
        .din   (rom_data),
        .dout  (cur_word)
    );

    useq_branch_unit #(.N_UOPS(N_UOPS), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_br (
        .word   (cur_word),
        .cond   (cond),
        .uops   (cur_uops),
        .is_end (cur_end),
        .taken  (cur_taken),
        .target (cur_target)
    );

    // Output drive: enables appear only in the execute state.
    always_comb begin
        uop_valid  = (state == SQ_EXEC);
        opc_ready  = (state == SQ_IDLE);
        uop        = uop_valid ? cur_uops : '0;
        instr_done = uop_valid & cur_end;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        opc_ready |-> (!uop_valid && uop == '0 && !instr_done));      // R1
    AST_ACCEPT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_valid && opc_ready) |=>
            (!uop_valid && rom_addr == (ADDR_W'($past(opc)) << START_SH))); // R2
    AST_PREFETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !instr_done && !cur_taken) |=>
            (uop_valid && rom_addr == $past(rom_addr) + 1'b1));       // R4
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> (opc_ready && !uop_valid));                    // R5
    AST_TAKEN_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && cur_taken && !instr_done) |=>
            (!uop_valid && uop == '0 && rom_addr == $past(cur_target))); // R6
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !instr_done) |=> !opc_ready);                   // R9
endmodule

// File: tb/useq_sequencer_tb.sv
`timescale 1ns/1ps
// Bench: microprogram table computed arithmetically; every opcode is swept
// under several condition patterns and checked cycle by cycle.
module useq_sequencer_tb;
    localparam int N_UOPS = 8;
    localparam int ADDR_W = 6;
    localparam int OPC_W  = 4;
    localparam int WORD_W = N_UOPS + 2 + 4 + ADDR_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              opc_valid = 1'b0;
    logic [OPC_W-1:0]  opc = '0;
    logic [15:0]       cond = '0;
    logic [WORD_W-1:0] rom_data;
    logic [ADDR_W-1:0] rom_addr;
    logic              opc_ready, uop_valid, instr_done;
    logic [N_UOPS-1:0] uop;

    logic [WORD_W-1:0] rom [DEPTH];
    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign rom_data = rom[rom_addr];

    useq_sequencer #(.N_UOPS(N_UOPS), .ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .opc_valid(opc_valid), .opc(opc),
        .cond(cond), .rom_data(rom_data), .rom_addr(rom_addr),
        .opc_ready(opc_ready), .uop(uop), .uop_valid(uop_valid),
        .instr_done(instr_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Fields: uops[7:0], end[8], transfer[9], select[13:10], target[19:14].
    task automatic build_rom();
        for (int a = 0; a < DEPTH; a++) begin
            logic [WORD_W-1:0] w;
            w = '0;
            w[7:0] = 8'(a * 37 + 5) | 8'h81;
            if ((a % 4) == 3 && a != DEPTH - 1) w[8] = 1'b1;
            if ((a % 4) == 1 && (a / 4) >= 4 && (a / 4) <= 13) begin
                w[9]     = 1'b1;
                w[13:10] = 4'(a / 4);
                w[19:14] = 6'((a + 7) % DEPTH);
            end
            if (a == 4) begin w[9] = 1'b1; w[13:10] = 4'd2; w[19:14] = 6'd20; end
            if (a == 8) begin w[8] = 1'b1; w[9] = 1'b1; w[13:10] = 4'd0; w[19:14] = 6'd40; end
            rom[a] = w;
        end
    endtask

    task automatic check_idle(input string req);
        chk(opc_ready == 1'b1, req, int'(opc_ready), 1);
        chk(uop_valid == 1'b0, req, int'(uop_valid), 0);
        chk(uop == '0, req, int'(uop), 0);
        chk(instr_done == 1'b0, req, int'(instr_done), 0);
    endtask

    // Runs one machine instruction from a negedge at which the DUT is idle.
    task automatic run_opc(input logic [OPC_W-1:0] code, input bit noisy);
        int a, steps;
        bit done;
        logic [WORD_W-1:0] w;
        chk(opc_ready == 1'b1, "R2 ready before accept", int'(opc_ready), 1);
        opc = code;
        opc_valid = 1'b1;
        @(negedge clk);
        if (noisy) opc = code ^ 4'h5;   // R9: offered while busy
        else opc_valid = 1'b0;
        a = int'(code) * (1 << (ADDR_W - OPC_W));
        chk(rom_addr == ADDR_W'(a), "R2 start address", int'(rom_addr), a);
        chk(uop_valid == 1'b0, "R2 fill cycle", int'(uop_valid), 0);
        done = 0;
        steps = 0;
        while (!done && steps < 40) begin
            steps++;
            @(negedge clk);
            w = rom[a];
            chk(uop_valid == 1'b1, "R3 issue valid", int'(uop_valid), 1);
            chk(uop == w[7:0], "R3 enables", int'(uop), int'(w[7:0]));
            chk(rom_addr == ADDR_W'((a + 1) % DEPTH), "R4 prefetch address",
                int'(rom_addr), (a + 1) % DEPTH);
            if (w[8]) begin
                chk(instr_done == 1'b1, w[9] ? "R8 end beats transfer" : "R5 done",
                    int'(instr_done), 1);
                opc_valid = 1'b0;
                @(negedge clk);
                check_idle(w[9] ? "R8 back to idle" : "R5 back to idle");
                done = 1;
            end else begin
                chk(instr_done == 1'b0, "R5 no early done", int'(instr_done), 0);
                if (w[9] && cond[w[13:10]]) begin
                    @(negedge clk);
                    chk(uop_valid == 1'b0, "R6 bubble valid", int'(uop_valid), 0);
                    chk(uop == '0, "R6 bubble enables", int'(uop), 0);
                    chk(rom_addr == w[19:14], "R6 target fetch", int'(rom_addr), int'(w[19:14]));
                    a = int'(w[19:14]);
                end else begin
                    a = (a + 1) % DEPTH;   // R4 / R7: next word without gap
                end
            end
        end
        if (!done) chk(1'b0, "R5 routine never ended", steps, 0);
        opc_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [15:0] pats [4];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5A5; pats[3] = 16'h5A5A;
        build_rom();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_idle("R1 after reset");
        chk(rom_addr == '0, "R1 address", int'(rom_addr), 0);
        @(negedge clk);
        check_idle("R1 stays idle");

        foreach (pats[p]) begin
            cond = pats[p];
            for (int c = 0; c < (1 << OPC_W); c++)
                run_opc(OPC_W'(c), (c % 3) == 0);
        end

        // R7: transfer word at 4 with its condition low, then R6 with it high.
        cond = 16'h0000;
        run_opc(4'd1, 1'b0);
        cond = 16'h0004;
        run_opc(4'd1, 1'b1);
        // R8: end+transfer word with every condition high.
        cond = 16'hFFFF;
        run_opc(4'd2, 1'b0);
        // R4: routine crossing the top of the store (63 -> 0).
        run_opc(4'd15, 1'b0);

        // R10: reset in the middle of a routine.
        cond = 16'h0000;
        opc = 4'd1;
        opc_valid = 1'b1;
        @(negedge clk);
        opc_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(uop_valid == 1'b1, "R10 busy before reset", int'(uop_valid), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_idle("R10 idle after reset");
        chk(rom_addr == '0, "R10 address cleared", int'(rom_addr), 0);
        run_opc(4'd0, 1'b0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule